// File: doc/BRIEF.md
# Memory Parity Checker and Control Register

This block works beside a DRAM controller and handles byte-lane parity for local memory. On each memory write it produces one parity bit for every byte lane, and the DRAM stores those bits next to the data. On each memory read it checks the returned data against the returned parity bits. When it finds a mismatch, it sets a latched non-maskable interrupt request.

A control register lets software turn error detection on or off, clear a pending error, and select a test mode. In test mode the block stores wrong parity, so software can force an error at an address it picks. The register answers anywhere inside its own address block. A read of the register ends in a bus error unless an error is pending, so software can use the read to find the interrupt source.

The block also finds out by itself whether parity memory is fitted. It starts out assuming the parity memory is absent. It marks the memory present the first time a read of the low byte lane returns a 0 on that lane's parity line. Until then it never reports an error.

Top module: `mem_parity_ctl`

## Requirements
- R1: `wr_par[i]` is the XOR of the eight bits of `wr_data` lane i (lane i = bits 8i+7..8i), so each lane plus its parity bit holds an even number of ones. This holds whatever the detection-enable state is, while the test mode is off.
- R2: A control-register write whose low data byte has bit 0 = 1 enables error detection. A write whose low data byte has bit 0 = 0 disables detection and clears any pending error.
- R3: A detected error sets `nmi` from the next clock. `nmi` stays high until reset or until a clearing write (R2). If a detection and a clearing write happen in the same cycle, the detection wins.
- R4: A control-register read gets `reg_berr` (with `reg_ack` low) one cycle later when no error is pending. When an error is pending, it gets `reg_ack` (with `reg_berr` low) instead. `reg_ack` and `reg_berr` are never high together.
- R5: Bit 1 of the low data byte of a control-register write selects the wrong-parity test mode. In that mode every `wr_par` bit is inverted compared with R1. Checking always expects even parity.
- R6: After reset, parity memory is marked absent. It becomes present after a cycle in which `rd_valid` is high, `rd_be[0]` is high and `rd_par[0]` is 0.
- R7: Control-register writes get `reg_ack` one cycle later, never `reg_berr`, even when parity memory is absent.
- R8: While parity memory is marked absent, no read sets `nmi`, whatever the enable bit is.
- R9: Only lanes with their `rd_be` bit high are checked. A mismatch on an unselected lane has no effect.
- R10: The register answers for every address whose bits above bit 15 equal 0x5B. Data bits above bit 7 are ignored. A request outside the block gets neither `reg_ack` nor `reg_berr`.
- R11: After reset `nmi`, `reg_ack` and `reg_berr` are low and the test mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | CPU register access strobe, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 24 | CPU byte address |
| reg_wdata | input | 16 | CPU write data; only the low byte is used |
| reg_ack | output | 1 | Access completed, one cycle after the request |
| reg_berr | output | 1 | Access ended in a bus error, one cycle after the request |
| wr_data | input | 16 | Data being written to memory |
| wr_par | output | 2 | Parity bits to store, one per lane |
| rd_valid | input | 1 | Memory read data is valid this cycle |
| rd_be | input | 2 | Byte lanes taking part in the read |
| rd_data | input | 16 | Data read from memory |
| rd_par | input | 2 | Parity bits read from memory |
| nmi | output | 1 | Latched parity-error interrupt request |

## Verification
Most of the internal state can be seen at the ports within one cycle. A wrong pending flag shows up both on `nmi` and on whether the next register read ends in a bus error. A wrong test-mode bit shows up at once on `wr_par`. The enable and presence flags have no output of their own, so a wrong value there stays hidden until a faulty read either raises `nmi` on the following clock or fails to. The bench therefore runs faulty reads before and after each change to these flags.

// File: rtl/mem_parity_ctl.sv
module mem_parity_ctl #(
  parameter int LANES = 2,
  parameter int AW = 24,
  parameter int BLK_W = 16,
  parameter logic [AW-1:0] CTRL_BASE = 24'h5B0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [8*LANES-1:0]   reg_wdata,
  output logic                 reg_ack,
  output logic                 reg_berr,
  input  logic [8*LANES-1:0]   wr_data,
  output logic [LANES-1:0]     wr_par,
  input  logic                 rd_valid,
  input  logic [LANES-1:0]     rd_be,
  input  logic [8*LANES-1:0]   rd_data,
  input  logic [LANES-1:0]     rd_par,
  output logic                 nmi
);
  localparam int DW = 8 * LANES;

  logic en_q, odd_q, present_q, pend_q;
  logic [LANES-1:0] lane_even, rd_bad;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_even[i] = ^wr_data[8*i +: 8];
      rd_bad[i]    = ^{rd_data[8*i +: 8], rd_par[i]};
    end
  end

  assign wr_par = lane_even ^ {LANES{odd_q}};

  wire hit    = reg_req && (reg_addr[AW-1:BLK_W] == CTRL_BASE[AW-1:BLK_W]);
  wire ctl_wr = hit && reg_we;
  wire clr    = ctl_wr && !reg_wdata[0];
  wire err    = rd_valid && present_q && en_q && |(rd_bad & rd_be);
  wire seen   = rd_valid && rd_be[0] && !rd_par[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      odd_q     <= 1'b0;
      present_q <= 1'b0;
      pend_q    <= 1'b0;
      reg_ack   <= 1'b0;
      reg_berr  <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q  <= reg_wdata[0];
        odd_q <= reg_wdata[1];
      end
      if (seen) present_q <= 1'b1;
      pend_q   <= err || (pend_q && !clr);
      reg_ack  <= hit && (reg_we || pend_q);
      reg_berr <= hit && !reg_we && !pend_q;
    end
  end

  assign nmi = pend_q;

  a_r3_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    nmi && !clr |=> nmi);
  a_r3_rise_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(rd_valid));
  a_r4_berr_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !reg_we && !nmi |=> reg_berr && !reg_ack);
  a_r4_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_ack && reg_berr));
  a_r7_write_acks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> reg_ack && !reg_berr);
  a_r8_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !present_q && !nmi |=> !nmi);
  a_r6_presence_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    present_q |=> present_q);
  a_r10_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !reg_ack && !reg_berr);
endmodule

// File: tb/mem_parity_ctl_test.sv
module mem_parity_ctl_test;
  logic clk = 0, rst_n = 0;
  logic reg_req = 0, reg_we = 0;
  logic [23:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, wr_data = 0, rd_data = 0;
  logic rd_valid = 0;
  logic [1:0] rd_be = 0, rd_par = 0;
  logic reg_ack, reg_berr, nmi;
  logic [1:0] wr_par;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  bit m_en, m_odd, m_pres, m_pend, m_ack, m_berr;

  always #10 clk = ~clk;

  mem_parity_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_berr(reg_berr), .wr_data(wr_data),
    .wr_par(wr_par), .rd_valid(rd_valid), .rd_be(rd_be), .rd_data(rd_data),
    .rd_par(rd_par), .nmi(nmi));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, err;
    if (!rst_n) begin
      m_en = 0; m_odd = 0; m_pres = 0; m_pend = 0; m_ack = 0; m_berr = 0;
    end else begin
      hit = reg_req && (int'(reg_addr) / 65536 == 'h5B);
      err = 0;
      for (int i = 0; i < 2; i++)
        if (rd_be[i] && (($countones(rd_data[8*i +: 8]) + rd_par[i]) % 2 == 1)) err = 1;
      err = err && rd_valid && m_pres && m_en;
      m_ack  = hit && (reg_we || m_pend);
      m_berr = hit && !reg_we && !m_pend;
      if (err) m_pend = 1;
      else if (hit && reg_we && reg_wdata[0] == 0) m_pend = 0;
      if (hit && reg_we) begin m_en = reg_wdata[0]; m_odd = reg_wdata[1]; end
      if (rd_valid && rd_be[0] && !rd_par[0]) m_pres = 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    for (int i = 0; i < 2; i++)
      chk("R1 wr_par", wr_par[i], ($countones(wr_data[8*i +: 8]) % 2) ^ m_odd);
    chk("R3 nmi", nmi, m_pend);
    chk("R7 reg_ack", reg_ack, m_ack);
    chk("R4 reg_berr", reg_berr, m_berr);
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    @(posedge clk); #2;
    reg_req = 0; reg_we = 0; rd_valid = 0; rd_be = 0; rd_par = 0; rd_data = 0;
  endtask
  task automatic cpu(bit we, logic [23:0] a, logic [15:0] d);
    @(posedge clk); #2;
    reg_req = 1; reg_we = we; reg_addr = a; reg_wdata = d; rd_valid = 0;
  endtask
  task automatic mrd(logic [1:0] be, logic [15:0] d, logic [1:0] p);
    @(posedge clk); #2;
    reg_req = 0; rd_valid = 1; rd_be = be; rd_data = d; rd_par = p;
  endtask
  task automatic settle();
    idle(); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 nmi after reset", nmi, 0);
    chk("R11 ack after reset", reg_ack, 0);
    wr_data = 16'h0301; #1;
    chk("R11 even parity after reset", wr_par, 2'b01);
    @(posedge clk); #2 rst_n = 1;
    cpu(1, 24'h5B0000, 16'h0001); settle();          // R7 write acks while absent
    chk("R7 absent write no berr", reg_berr, 0);
    mrd(2'b11, 16'h0000, 2'b01); settle();           // R8 mismatch, memory absent
    chk("R8 no error while absent", nmi, 0);
    mrd(2'b01, 16'h0000, 2'b00); settle();           // R6 presence seen
    cpu(0, 24'h5B1234, 0); idle(); @(negedge clk);
    chk("R4 berr with nothing pending", reg_berr, 1);
    mrd(2'b01, 16'h0100, 2'b00); settle();           // R9 lane 1 bad, not selected
    chk("R9 unselected lane ignored", nmi, 0);
    mrd(2'b10, 16'h0100, 2'b00); settle();
    chk("R6 present so error flagged", nmi, 1);
    cpu(0, 24'h5BFFFE, 0); idle(); @(negedge clk);
    chk("R10 read at block end acks", reg_ack, 1);
    cpu(1, 24'h5B0002, 16'hFF01); settle();
    chk("R2 enable write keeps pending", nmi, 1);
    cpu(1, 24'h5B8000, 16'h0100); settle();
    chk("R10 high byte ignored, cleared", nmi, 0);
    cpu(0, 24'h5C0000, 0); idle(); @(negedge clk);
    chk("R10 outside block silent", reg_ack | reg_berr, 0);
    mrd(2'b11, 16'h0001, 2'b00); settle();
    chk("R2 disabled detection", nmi, 0);
    cpu(1, 24'h5B0000, 16'h0002); idle(); wr_data = 16'h0301; @(negedge clk);
    chk("R5 odd parity stored", wr_par, 2'b10);
    cpu(1, 24'h5B0000, 16'h0003); settle();
    mrd(2'b01, 16'h0001, 2'b00); settle();
    chk("R5 odd stored data flagged", nmi, 1);
    @(posedge clk); #2;                               // R3 detection beats clear
    reg_req = 1; reg_we = 1; reg_addr = 24'h5B0000; reg_wdata = 0;
    rd_valid = 1; rd_be = 2'b01; rd_data = 16'h0001; rd_par = 2'b00;
    settle();
    chk("R3 same-cycle detect wins", nmi, 1);
    cpu(1, 24'h5B0000, 0); settle();
    chk("R3 later clear", nmi, 0);
    @(posedge clk); #2 rst_n = 0; settle(); #2 rst_n = 1;
    mrd(2'b11, 16'h0003, 2'b11); settle();
    cpu(1, 24'h5B0000, 16'h0001); settle();
    mrd(2'b10, 16'h0100, 2'b01); settle();
    chk("R6 absent again after reset", nmi, 0);
    repeat (3) settle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule